// File: doc/BRIEF.md
# Multi-Rail Power-On Reset Supervisor

This block turns a set of per-supply "voltage above trip" flags into one main reset for a configurable device. Each flag comes from an analog comparator that sits outside the block. Every flag passes through its own two-flop synchronizer. A mode input chooses which core-supply flag counts: the regulated core flag in single-supply mode, or the external core flag in dual-supply mode. The analog-supply flag and one I/O-bank flag count in both modes. The PLL digital, ADC analog and internal core flags are accepted at the port but never used.

Main reset stays asserted while any monitored rail is low. The wait starts when the last monitored rail goes good. Reset is released after a fixed delay counted in clock cycles; the default equals 2.5 ms at the given clock period. A one-cycle `config_start` pulse then tells the configuration engine that it may begin.

After release the block keeps watching for brown-out. A drop on the core or analog flag returns it to reset at any time. A drop on the I/O flag only causes a reset within a window counted from the moment the last rail reached trip; the default window is 9 ms. After that window, an I/O drop is ignored.

Top module: `rail_reset_supervisor`

## Requirements
- R1: While `rst_n` is low, and afterwards while any monitored rail flag is low, `main_reset` is 1 and `config_start` is 0.
- R2: When the last monitored flag rises, `main_reset` is still 1 after POR_DELAY_CYC+2 rising edges and 0 after POR_DELAY_CYC+3 edges (2 synchronizer stages, 1 sequencer cycle, then the delay).
- R3: `config_start` is high for exactly one cycle: the first cycle in which `main_reset` is 0. It is never high while `main_reset` is 1.
- R4: Rail flag positions are: bit 0 regulated core, bit 1 external core, bit 2 analog, bit 3 I/O bank. With `dual_mode`=0 the monitored set is bits 0, 2 and 3. With `dual_mode`=1 it is bits 1, 2 and 3.
- R5: Bits 4 (PLL digital), 5 (ADC analog) and 6 (internal core), and the core bit that the current mode does not select, have no effect on `main_reset` or `config_start`.
- R6: After release, a fall of the selected core flag or of the analog flag sets `main_reset` to 1 on the third rising edge after the change, and the block starts again from reset.
- R7: An I/O flag fall re-asserts `main_reset` when it is seen before IO_WINDOW_CYC cycles have passed since the last rail went good. After that window it has no effect.
- R8: A monitored flag that falls during the delay cancels it. The full delay is counted again from the next time all rails are good.
- R9: `dual_mode` is sampled only while the block waits in reset. A change after release has no effect.
- R10: If a monitored flag fall reaches the sequencer in the same cycle the delay would expire, the drop wins: no `config_start` is issued and `main_reset` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock; its period sets all timing |
| rst_n | input | 1 | Asynchronous active-low reset |
| dual_mode | input | 1 | 0 = single-supply rail set, 1 = dual-supply rail set |
| rail_ok | input | 7 | Asynchronous per-rail above-trip flags (bit map in R4, R5) |
| main_reset | output | 1 | Main reset, 1 = device held in reset |
| config_start | output | 1 | One-cycle pulse allowing configuration to begin |

## Verification
The delicate coincidence is a monitored rail falling in the very cycle the power-on delay runs out. In that cycle the sequencer could either release or restart. The bench drives a rail drop exactly POR_DELAY_CYC edges after the rails went good, so that the synchronized drop lands on the expiry cycle. It then requires that `main_reset` never falls and that no `config_start` pulse is counted. A second overlap is an I/O drop while the window is still open, just after release. This is checked against the same drop made well after the window has closed.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

  // Rail flag positions on the rail_ok bus
  localparam int RAIL_COUNT    = 7;
  localparam int IDX_CORE_REG  = 0;
  localparam int IDX_CORE_EXT  = 1;
  localparam int IDX_ANALOG    = 2;
  localparam int IDX_IO_BANK   = 3;
  localparam int IDX_PLL_DIG   = 4;
  localparam int IDX_ADC_ANA   = 5;
  localparam int IDX_CORE_INT  = 6;

  localparam logic [RAIL_COUNT-1:0] CORE_GROUP =
    (RAIL_COUNT'(1) << IDX_CORE_REG) | (RAIL_COUNT'(1) << IDX_CORE_EXT) |
    (RAIL_COUNT'(1) << IDX_ANALOG);
  localparam logic [RAIL_COUNT-1:0] IO_GROUP = RAIL_COUNT'(1) << IDX_IO_BANK;

  localparam logic [RAIL_COUNT-1:0] SET_SINGLE =
    (RAIL_COUNT'(1) << IDX_CORE_REG) | (RAIL_COUNT'(1) << IDX_ANALOG) | IO_GROUP;
  localparam logic [RAIL_COUNT-1:0] SET_DUAL =
    (RAIL_COUNT'(1) << IDX_CORE_EXT) | (RAIL_COUNT'(1) << IDX_ANALOG) | IO_GROUP;

  typedef enum logic [1:0] {
    RESET_WAIT     = 2'd0,
    POR_DELAY      = 2'd1,
    CONFIG_RELEASE = 2'd2,
    USER           = 2'd3
  } rsv_state_e;

endpackage

// File: rtl/rsv_sync.sv
module rsv_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
      chain_d = (chain_q << 1) | STAGES'(d_async[g]);
    end

    // Clears to "rail low" so a reset never looks like a good supply
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= chain_d;
    end

    assign q_sync[g] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/rsv_rail_select.sv
module rsv_rail_select
  import rsv_pkg::*;
(
  input  logic [RAIL_COUNT-1:0] rails_s,
  input  logic                  mode_dual,
  output logic                  core_ok,
  output logic                  io_ok,
  output logic                  all_good
);

  logic [RAIL_COUNT-1:0] watch_set;

  always_comb begin
    watch_set = mode_dual ? SET_DUAL : SET_SINGLE;
    // A rail outside the watch set is forced good, so it cannot matter
    core_ok   = &(rails_s | ~(watch_set & CORE_GROUP));
    io_ok     = &(rails_s | ~(watch_set & IO_GROUP));
    all_good  = core_ok & io_ok;
  end

endmodule

// File: rtl/rsv_timer.sv
module rsv_timer #(
  parameter int DELAY_CYC  = 250000,
  parameter int WINDOW_CYC = 900000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic advance,
  output logic delay_done,
  output logic window_open
);

  localparam int CW = $clog2(WINDOW_CYC + 1);
  localparam logic [CW-1:0] DELAY_LAST = CW'(DELAY_CYC - 1);
  localparam logic [CW-1:0] WIN_LIMIT  = CW'(WINDOW_CYC);

  logic [CW-1:0] elapsed_q;
  logic [CW-1:0] elapsed_d;
  logic          elapsed_en;

  always_comb begin
    elapsed_en = clear | (advance & (elapsed_q != WIN_LIMIT));
    elapsed_d  = clear ? '0 : elapsed_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          elapsed_q <= '0;
    else if (elapsed_en) elapsed_q <= elapsed_d;
  end

  assign delay_done  = (elapsed_q == DELAY_LAST);
  assign window_open = (elapsed_q < WIN_LIMIT);

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    elapsed_q <= WIN_LIMIT);

  // R8
  cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (elapsed_q == '0));

endmodule

// File: rtl/rail_reset_supervisor.sv
module rail_reset_supervisor
  import rsv_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 10,
  parameter int POR_DELAY_CYC = 2_500_000 / CLK_PERIOD_NS,
  parameter int IO_WINDOW_CYC = 9_000_000 / CLK_PERIOD_NS,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  dual_mode,
  input  logic [RAIL_COUNT-1:0] rail_ok,
  output logic                  main_reset,
  output logic                  config_start
);

  logic [RAIL_COUNT-1:0] rails_s;
  logic       mode_q, mode_d;
  logic       core_ok, io_ok, all_good;
  rsv_state_e state_q, state_d;
  logic       tmr_clear, tmr_adv, delay_done, window_open;
  logic       reset_d, start_d;

  rsv_sync #(.WIDTH(RAIL_COUNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (rail_ok),
    .q_sync  (rails_s)
  );

  rsv_rail_select u_select (
    .rails_s   (rails_s),
    .mode_dual (mode_q),
    .core_ok   (core_ok),
    .io_ok     (io_ok),
    .all_good  (all_good)
  );

  rsv_timer #(.DELAY_CYC(POR_DELAY_CYC), .WINDOW_CYC(IO_WINDOW_CYC)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (tmr_clear),
    .advance     (tmr_adv),
    .delay_done  (delay_done),
    .window_open (window_open)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      RESET_WAIT: begin
        if (all_good) state_d = POR_DELAY;
      end
      POR_DELAY: begin
        // A drop takes priority over expiry of the delay
        if (!all_good)       state_d = RESET_WAIT;
        else if (delay_done) state_d = CONFIG_RELEASE;
      end
      CONFIG_RELEASE, USER: begin
        if (!core_ok || (!io_ok && window_open)) state_d = RESET_WAIT;
        else                                     state_d = USER;
      end
      default: state_d = RESET_WAIT;
    endcase

    tmr_clear = (state_q == RESET_WAIT);
    tmr_adv   = (state_q != RESET_WAIT);
    mode_d    = (state_q == RESET_WAIT) ? dual_mode : mode_q;
    reset_d   = !((state_d == CONFIG_RELEASE) || (state_d == USER));
    start_d   = (state_d == CONFIG_RELEASE);
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= RESET_WAIT;
      mode_q       <= 1'b0;
      main_reset   <= 1'b1;
      config_start <= 1'b0;
    end else begin
      state_q      <= state_d;
      mode_q       <= mode_d;
      main_reset   <= reset_d;
      config_start <= start_d;
    end
  end

  // R1
  hold_in_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RESET_WAIT) |-> main_reset);

  // R3
  start_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    config_start |-> !main_reset);

  // R3
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    config_start |=> !config_start);

  // R3
  release_has_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(main_reset) |-> config_start);

  // R6
  core_brownout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == USER) && !core_ok) |=> main_reset);

  // R7
  io_late_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == USER) && core_ok && !window_open) |=> !main_reset);

  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != RESET_WAIT) |=> $stable(mode_q));

  // R10
  drop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == POR_DELAY) && !all_good) |=> (main_reset && !config_start));

endmodule

// File: tb/test_rail_reset_supervisor.sv
`timescale 1ns/1ps
module test_rail_reset_supervisor;
  import rsv_pkg::*;

  localparam int DLY = 40;
  localparam int WIN = 120;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dual_mode = 1'b0;
  logic [RAIL_COUNT-1:0] rail_ok = '0;
  logic main_reset, config_start;

  int checks = 0;
  int fails = 0;
  int starts_seen = 0;

  always #5 clk = ~clk;

  rail_reset_supervisor #(
    .CLK_PERIOD_NS (10),
    .POR_DELAY_CYC (DLY),
    .IO_WINDOW_CYC (WIN),
    .SYNC_STAGES   (2)
  ) i_rail_reset_supervisor (
    .clk          (clk),
    .rst_n        (rst_n),
    .dual_mode    (dual_mode),
    .rail_ok      (rail_ok),
    .main_reset   (main_reset),
    .config_start (config_start)
  );

  always @(negedge clk) if (config_start === 1'b1) starts_seen++;

  task automatic check_bit(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_int(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  function automatic logic rails_good(logic [RAIL_COUNT-1:0] f, logic m);
    return f[IDX_ANALOG] & f[IDX_IO_BANK] & (m ? f[IDX_CORE_EXT] : f[IDX_CORE_REG]);
  endfunction

  function automatic logic [RAIL_COUNT-1:0] needed(logic m);
    return m ? 7'b0001110 : 7'b0001101;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(1);
  endtask

  // Apply rails from the waiting state and check the exact release cycle
  task automatic bring_up(logic m, logic [RAIL_COUNT-1:0] f);
    dual_mode = m;
    rail_ok   = f;
    tick(DLY + 2);
    check_bit("R2 still held", main_reset, 1'b1);
    tick(1);
    check_bit("R2 released", main_reset, 1'b0);
    check_bit("R3 start pulse", config_start, 1'b1);
    tick(1);
    check_bit("R3 pulse ends", config_start, 1'b0);
    check_bit("R3 stays released", main_reset, 1'b0);
  endtask

  initial begin
    #1_500_000;
    fails++;
    checks++;
    $display("FAIL watchdog R1: run still active at %0t, expected finish", $time);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int s0;
    void'($urandom(32'd2024));

    // R1 reset state
    tick(3);
    check_bit("R1 reset main_reset", main_reset, 1'b1);
    check_bit("R1 reset config_start", config_start, 1'b0);
    rst_n = 1'b1;
    tick(1);

    // R4 single mode ignores external core flag; regulated core missing
    rail_ok = 7'b1111110;
    tick(DLY + 20);
    check_bit("R4 single set missing core", main_reset, 1'b1);
    check_int("R1 no start while held", starts_seen, 0);

    // R2/R3 release in single mode
    bring_up(1'b0, 7'b0001101);

    // R7 I/O drop inside window
    tick(20);
    rail_ok[IDX_IO_BANK] = 1'b0;
    tick(3);
    check_bit("R7 io drop in window", main_reset, 1'b1);
    bring_up(1'b0, 7'b0001101);

    // R7 I/O drop after window
    tick(WIN + 10);
    rail_ok[IDX_IO_BANK] = 1'b0;
    tick(5);
    check_bit("R7 io drop after window", main_reset, 1'b0);
    rail_ok[IDX_IO_BANK] = 1'b1;

    // R5 unmonitored and unselected flags toggle freely
    s0 = starts_seen;
    for (int i = 0; i < 50; i++) begin
      logic [31:0] r;
      r = $urandom;
      rail_ok = {r[2:0], 1'b1, 1'b1, r[3], 1'b1};
      tick(1);
      check_bit("R5 ignored flags", main_reset, 1'b0);
    end
    tick(3);
    check_bit("R5 after toggles", main_reset, 1'b0);
    check_int("R5 no extra start", starts_seen, s0);

    // R9 mode change after release is ignored
    rail_ok = 7'b0001101;
    dual_mode = 1'b1;
    tick(6);
    check_bit("R9 mode ignored in user", main_reset, 1'b0);

    // R6 core brown-out, exact latency
    rail_ok[IDX_CORE_REG] = 1'b0;
    tick(2);
    check_bit("R6 core drop not yet", main_reset, 1'b0);
    tick(1);
    check_bit("R6 core drop reset", main_reset, 1'b1);

    // R4 dual mode set
    bring_up(1'b1, 7'b0001110);

    // R6 analog brown-out long after window
    tick(WIN + 5);
    rail_ok[IDX_ANALOG] = 1'b0;
    tick(2);
    check_bit("R6 analog drop not yet", main_reset, 1'b0);
    tick(1);
    check_bit("R6 analog drop reset", main_reset, 1'b1);

    // R8 drop during delay restarts the count
    rail_ok = 7'b0001110;
    tick(10);
    rail_ok[IDX_IO_BANK] = 1'b0;
    tick(3);
    rail_ok[IDX_IO_BANK] = 1'b1;
    tick(DLY + 2);
    check_bit("R8 restarted still held", main_reset, 1'b1);
    tick(1);
    check_bit("R8 restarted release", main_reset, 1'b0);

    // R10 drop lands on the expiry cycle
    rail_ok[IDX_ANALOG] = 1'b0;
    tick(4);
    check_bit("R10 setup reset", main_reset, 1'b1);
    rail_ok = 7'b0001110;
    tick(DLY);
    s0 = starts_seen;
    rail_ok[IDX_ANALOG] = 1'b0;
    for (int i = 0; i < 6; i++) begin
      tick(1);
      check_bit("R10 held through expiry", main_reset, 1'b1);
    end
    check_int("R10 no start pulse", starts_seen, s0);

    // R1/R2/R3 random rail patterns against the model
    for (int i = 0; i < 30; i++) begin
      logic m;
      logic [RAIL_COUNT-1:0] f;
      logic ok;
      do_reset();
      m = 1'($urandom % 2);
      f = RAIL_COUNT'($urandom);
      if ($urandom % 2 == 0) f = f | needed(m);
      ok = rails_good(f, m);
      dual_mode = m;
      rail_ok = f;
      s0 = starts_seen;
      tick(DLY + 4);
      check_bit("R1 random main_reset", main_reset, !ok);
      check_int("R3 random start count", starts_seen - s0, ok ? 1 : 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule